// File: doc/BRIEF.md
# Serial ADC Conversion Host

This block runs one analog-to-digital conversion at a time on an external 12-bit serial converter. The link is SPI mode 0: the clock idles low, the host changes its output after a falling edge, and it captures the converter's output at a rising edge. A request carries a channel number, a polarity flag, an input-mode flag and a two-bit clock/power mode. The block lowers chip-select and shifts out a control byte built from those fields. It then clocks two more bytes to collect the conversion result, raises chip-select, and presents the 12-bit result with a one-cycle valid pulse.

The serial clock is derived from the system clock. Each high and each low phase lasts `HALF_CYC` system cycles. `HALF_CYC` is chosen so that the clock stays at or below 2 MHz and each phase lasts at least 200 ns, which also covers the 100 ns chip-select and data setup times. When the request selects the converter's own conversion clock (mode 2'b10), the block stops the serial clock after the control byte. It waits for the converter's end-of-conversion strobe to rise and only then reads the result.

Top module: `adc_spi_host`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `req_ready` is 1 and `res_valid` is 0.
- R2: An accepted request drives this control byte on `spi_mosi`, MSB first: bit 7 = 1, bits 6:4 = `req_chan`, bit 3 = `req_unipolar`, bit 2 = `req_single`, bits 1:0 = `req_mode`. Each bit is valid before its rising edge and stays stable while `spi_sclk` is high.
- R3: Every high phase of `spi_sclk` lasts exactly `HALF_CYC` cycles, and every low phase lasts at least `HALF_CYC` cycles. `spi_sclk` is low whenever `spi_cs_n` is high.
- R4: The first rising edge of `spi_sclk` comes exactly `HALF_CYC` cycles after `spi_cs_n` falls.
- R5: One conversion frame contains exactly 24 rising edges of `spi_sclk`.
- R6: `spi_mosi` is 0 during the 16 read clocks (rising edges 9 to 24) and whenever `spi_cs_n` is high.
- R7: The values of `spi_miso` sampled at rising edges 10 through 21 form `res_data`, from bit 11 down to bit 0. The samples at rising edges 1 to 9 and 22 to 24 have no effect on the result.
- R8: With `req_mode` = 2'b10, `spi_sclk` stays low after the 8th falling edge until a rise of `conv_strobe` is seen through a two-stage synchronizer. The 9th rising edge then comes `HALF_CYC`+3 cycles after the strobe input rises. With any other mode, the low phase before the 9th rising edge is exactly `HALF_CYC` cycles.
- R9: `spi_cs_n` rises `HALF_CYC` cycles after the 24th falling edge. `res_valid` is high for exactly that one cycle, and `res_data` keeps its value until the next completion.
- R10: `req_ready` is 1 only while no frame is in progress. A `req_valid` pulse while a frame is in progress starts no frame and does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a conversion; accepted when `req_ready` is 1 |
| req_chan | input | 3 | Channel select field of the control byte |
| req_unipolar | input | 1 | 1 = unipolar, 0 = bipolar |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_mode | input | 2 | Clock/power mode; 2'b10 = converter's own clock |
| req_ready | output | 1 | Host is idle and can accept a request |
| res_valid | output | 1 | One-cycle pulse when the result is ready |
| res_data | output | 12 | Conversion result |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| conv_strobe | input | 1 | End-of-conversion strobe from the converter (asynchronous) |

## Verification
Every output is a register, so a result appears at the edge after the decision that produces it. The first serial clock rise is due `HALF_CYC` cycles after chip-select falls, and each clock phase is due `HALF_CYC` cycles after the previous one. Chip-select rises, together with the valid pulse, `HALF_CYC` cycles after the 24th falling edge. In converter-clock mode the 9th rise is due `HALF_CYC`+3 cycles after the strobe input goes high. The bench samples every signal on the falling system-clock edge and keeps its own cycle count. It measures each of these gaps at the cycle where the edge is seen, so no check depends on event ordering at the active edge.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  localparam int CTRL_BITS  = 8;
  localparam int READ_BITS  = 16;
  localparam int FRAME_BITS = CTRL_BITS + READ_BITS;
  localparam int RES_W      = 12;
  // one leading acquisition bit, then the result, then padding
  localparam int RES_LSB    = READ_BITS - 1 - RES_W;
  localparam int CHAN_W     = 3;
  localparam int MODE_W     = 2;

  localparam logic [MODE_W-1:0] MODE_SELF_CLK = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_WAIT,
    ST_TAIL
  } seq_state_e;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              unipolar;
    logic              single;
    logic [MODE_W-1:0] mode;
  } conv_cfg_t;

  function automatic logic [CTRL_BITS-1:0] make_ctrl(conv_cfg_t c);
    return {1'b1, c.chan, c.unipolar, c.single, c.mode};
  endfunction

endpackage

// File: rtl/adc_spi_phase_timer.sv
module adc_spi_phase_timer #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || expire) cnt <= '0;
    else                        cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/adc_spi_strobe_sync.sv
module adc_spi_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/adc_spi_frame_seq.sv
module adc_spi_frame_seq
  import adc_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  conv_cfg_t        cfg,
  input  logic             expire,
  input  logic             strobe_rise,
  input  logic             miso,
  output logic             timer_clear,
  output logic             ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi
);
  localparam int BCNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);
  localparam logic [BCNT_W-1:0] CTRL_END = BCNT_W'(CTRL_BITS - 1);

  seq_state_e              state;
  logic [CTRL_BITS-1:0]    tx;
  logic [FRAME_BITS-1:0]   rx;
  logic [BCNT_W-1:0]       bitcnt;
  logic                    self_clk;
  logic [CTRL_BITS-1:0]    ctrl;

  assign ctrl        = make_ctrl(cfg);
  assign timer_clear = (state == ST_IDLE) || (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tx        <= '0;
      rx        <= '0;
      bitcnt    <= '0;
      self_clk  <= 1'b0;
      ready     <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            tx       <= {ctrl[CTRL_BITS-2:0], 1'b0};
            mosi     <= ctrl[CTRL_BITS-1];
            self_clk <= (cfg.mode == MODE_SELF_CLK);
            bitcnt   <= '0;
            cs_n     <= 1'b0;
            ready    <= 1'b0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (expire) begin
            sclk  <= 1'b1;
            rx    <= {rx[FRAME_BITS-2:0], miso};
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (expire) begin
            sclk   <= 1'b0;
            bitcnt <= bitcnt + BCNT_W'(1);
            mosi   <= tx[CTRL_BITS-1];
            tx     <= {tx[CTRL_BITS-2:0], 1'b0};
            if (bitcnt == LAST_BIT)                  state <= ST_TAIL;
            else if (bitcnt == CTRL_END && self_clk) state <= ST_WAIT;
            else                                     state <= ST_LOW;
          end
        end
        ST_WAIT: begin
          if (strobe_rise) state <= ST_LOW;
        end
        ST_TAIL: begin
          if (expire) begin
            cs_n      <= 1'b1;
            mosi      <= 1'b0;
            ready     <= 1'b1;
            res_valid <= 1'b1;
            res_data  <= rx[RES_LSB +: RES_W];
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_spi_host.sv
module adc_spi_host
  import adc_spi_pkg::*;
#(
  parameter int HALF_CYC    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_unipolar,
  input  logic              req_single,
  input  logic [MODE_W-1:0] req_mode,
  output logic              req_ready,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  input  logic              conv_strobe
);
  conv_cfg_t cfg;
  logic      expire;
  logic      timer_clear;
  logic      strobe_rise;

  assign cfg = '{chan: req_chan, unipolar: req_unipolar,
                 single: req_single, mode: req_mode};

  adc_spi_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (timer_clear),
    .expire (expire)
  );

  adc_spi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (conv_strobe),
    .rise     (strobe_rise)
  );

  adc_spi_frame_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (req_valid),
    .cfg         (cfg),
    .expire      (expire),
    .strobe_rise (strobe_rise),
    .miso        (spi_miso),
    .timer_clear (timer_clear),
    .ready       (req_ready),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .cs_n        (spi_cs_n),
    .sclk        (spi_sclk),
    .mosi        (spi_mosi)
  );
endmodule

// File: rtl/adc_spi_host_chk.sv
module adc_spi_host_chk #(
  parameter int HALF_CYC = 25
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic res_valid,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  logic        sclk_d;
  logic [15:0] hold_cnt;
  logic [15:0] cs_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      hold_cnt <= '0;
      cs_held  <= '0;
    end else begin
      sclk_d <= spi_sclk;
      if (spi_sclk != sclk_d)      hold_cnt <= 16'd1;
      else if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;
      if (spi_cs_n)                cs_held <= '0;
      else if (cs_held != 16'hFFFF) cs_held <= cs_held + 16'd1;
    end
  end

  assert_sclk_low_idle_R3: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  assert_phase_width_R3: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk != sclk_d) |-> (hold_cnt >= 16'(HALF_CYC)));

  assert_cs_lead_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> (cs_held >= 16'(HALF_CYC)));

  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && sclk_d) |-> $stable(spi_mosi));

  assert_mosi_low_idle_R6: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_mosi);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_done_at_cs_rise_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (spi_cs_n && ($past(spi_cs_n) == 1'b0)));

  assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);
endmodule

bind adc_spi_host adc_spi_host_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi)
);

// File: tb/adc_spi_host_bench.sv
module adc_spi_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_unipolar = 1'b0;
  logic        req_single = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_ready;
  logic        res_valid;
  logic [11:0] res_data;
  logic        spi_cs_n;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso = 1'b1;
  logic        conv_strobe = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural converter model and edge monitor state
  int          cyc = 0;
  int          rise_n = 0;
  int          fall_n = 0;
  int          frames = 0;
  int          cs_fall_cyc = 0;
  int          last_edge_cyc = 0;
  int          strobe_set_cyc = 0;
  int          strobe_due = 0;
  int          strobe_dly = 0;
  bit          strobe_armed = 0;
  bit          self_mode = 0;
  bit          got_done = 0;
  logic [23:0] din_cap = '0;
  logic [11:0] dev_result = '0;
  logic [11:0] got_res = '0;
  logic        sclk_prev = 1'b0;
  logic        cs_prev = 1'b1;

  adc_spi_host #(.HALF_CYC(HALF)) u_adc_spi_host (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_unipolar(req_unipolar), .req_single(req_single), .req_mode(req_mode),
    .req_ready(req_ready), .res_valid(res_valid), .res_data(res_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .conv_strobe(conv_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sampled on the inactive edge, once per system clock
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_cs_n) check(!spi_sclk, "R3 sclk idle", spi_sclk, 0);
      if (spi_cs_n) check(!spi_mosi, "R6 mosi idle", spi_mosi, 0);
      if (cs_prev && !spi_cs_n) begin
        frames++;
        cs_fall_cyc = cyc;
        last_edge_cyc = cyc;
        rise_n = 0;
        fall_n = 0;
        din_cap = '0;
        spi_miso = 1'b1;
      end
      if (!sclk_prev && spi_sclk) begin
        rise_n++;
        din_cap = {din_cap[22:0], spi_mosi};
        if (rise_n == 1) check(cyc - cs_fall_cyc == HALF, "R4 cs lead", cyc - cs_fall_cyc, HALF);
        else check(cyc - last_edge_cyc >= HALF, "R3 low phase", cyc - last_edge_cyc, HALF);
        if (rise_n == 9) begin
          if (self_mode) begin
            check(!strobe_armed, "R8 clock held until strobe", strobe_armed, 0);
            check(cyc - strobe_set_cyc == HALF + 3, "R8 strobe to rise", cyc - strobe_set_cyc, HALF + 3);
          end else begin
            check(cyc - last_edge_cyc == HALF, "R8 no pause", cyc - last_edge_cyc, HALF);
          end
        end
        last_edge_cyc = cyc;
      end
      if (sclk_prev && !spi_sclk) begin
        fall_n++;
        check(cyc - last_edge_cyc == HALF, "R3 high phase", cyc - last_edge_cyc, HALF);
        last_edge_cyc = cyc;
        begin
          int j;
          j = fall_n + 1 - 8;
          spi_miso = (j >= 2 && j <= 13) ? dev_result[13 - j] : 1'b1;
        end
        if (fall_n == 8) begin
          self_mode = (din_cap[1:0] == 2'b10);
          if (self_mode) begin
            conv_strobe = 1'b0;
            strobe_armed = 1;
            strobe_due = cyc + strobe_dly;
          end
        end
      end
      if (strobe_armed && cyc >= strobe_due) begin
        conv_strobe = 1'b1;
        strobe_set_cyc = cyc;
        strobe_armed = 0;
      end
      if (!cs_prev && spi_cs_n) begin
        check(cyc - last_edge_cyc == HALF, "R9 cs tail", cyc - last_edge_cyc, HALF);
        check(res_valid, "R9 valid with cs rise", res_valid, 1);
      end
      if (res_valid) begin
        got_done = 1;
        got_res = res_data;
      end
      sclk_prev = spi_sclk;
      cs_prev = spi_cs_n;
    end
  end

  task automatic run_conv(input logic [2:0] ch, input logic uni, input logic sgl,
                          input logic [1:0] mode, input logic [11:0] val,
                          input int sdly, input bit intrude);
    int guard;
    int frames_before;
    logic [7:0] exp_ctrl;
    exp_ctrl = {1'b1, ch, uni, sgl, mode};
    dev_result = val;
    strobe_dly = sdly;
    got_done = 0;
    @(negedge clk);
    check(req_ready, "R10 ready when idle", req_ready, 1);
    frames_before = frames;
    req_chan = ch; req_unipolar = uni; req_single = sgl; req_mode = mode;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      repeat (60) @(negedge clk);
      check(!req_ready, "R10 ready low when busy", req_ready, 0);
      req_chan = ~ch; req_unipolar = ~uni; req_single = ~sgl; req_mode = 2'b11;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!got_done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(got_done, "R9 completion", got_done, 1);
    check(rise_n == 24, "R5 rising edges", rise_n, 24);
    check(din_cap[23:16] == exp_ctrl, "R2 control byte", din_cap[23:16], exp_ctrl);
    check(din_cap[15:0] == 16'h0, "R6 mosi low in read", din_cap[15:0], 0);
    check(got_res == val, "R7 result", got_res, val);
    repeat (30) @(negedge clk);
    check(res_data == val, "R9 result held", res_data, val);
    check(!res_valid, "R9 valid single pulse", res_valid, 0);
    check(frames == frames_before + 1, "R10 one frame per request", frames, frames_before + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n, "R1 cs_n", spi_cs_n, 1);
    check(!spi_sclk, "R1 sclk", spi_sclk, 0);
    check(!spi_mosi, "R1 mosi", spi_mosi, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    check(!res_valid, "R1 valid", res_valid, 0);
    run_conv(3'd5, 1'b1, 1'b1, 2'b11, 12'hA5C, 0, 0);
    run_conv(3'd7, 1'b1, 1'b1, 2'b11, 12'hFFF, 0, 0);
    run_conv(3'd0, 1'b0, 1'b0, 2'b00, 12'h000, 0, 0);
    run_conv(3'd3, 1'b0, 1'b1, 2'b10, 12'h3C1, 40, 0);
    run_conv(3'd6, 1'b1, 1'b0, 2'b01, 12'h801, 0, 0);
    run_conv(3'd2, 1'b1, 1'b1, 2'b10, 12'h5A5, 5, 1);
    run_conv(3'd4, 1'b0, 1'b1, 2'b11, 12'h001, 0, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule